// File: doc/BRIEF.md
# PCIe Function Command Register and Access Gating

This block holds the 16-bit command register of an endpoint function, placed at configuration offset 0x04, and turns its enable bits into live decisions. Configuration software writes it with per-byte enables and reads it back. Inbound requests are classified by kind and answered either accepted or unsupported-request. Outbound requests from the internal master are granted or held back. A level-sensitive emulated interrupt line is converted into assert and deassert message requests. Detected errors and poisoned requests are routed to error-message request outputs.

A bit change acts on more than storage. Setting interrupt-disable withdraws an interrupt that is already signalled by issuing a deassert message. Completions leave regardless of bus-master enable. A disabled memory or I/O space turns matching inbound requests into unsupported-request responses. Packet formatting, the link layers, advanced error registers and the device control register are handled elsewhere; the device control report enables arrive as input bits.

Top module: `pcie_cmd_gate`

## Requirements
- R1: After reset every register bit is 0, a read at offset 0x04 returns 0x0000, and no message, grant or response output is high.
- R2: Only bits 10, 8, 6, 2, 1 and 0 (mask 0x0547) hold written values; bits 15:11 and bits 9, 7, 5, 4, 3 always read 0. A read strobe returns data with cfg_rd_valid high in the next cycle; a read at any offset other than 0x04 returns 0.
- R3: A write at offset 0x04 updates bits 7:0 only when cfg_be[0] is 1 and bits 15:8 only when cfg_be[1] is 1, taking effect on the cycle it is accepted; a write at any other offset changes nothing.
- R4: Request kinds are encoded 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 configuration, 5 message, 6 completion, 7 other. One cycle after an inbound request, in_resp_valid is 1 and in_resp_ur is 1 exactly when a memory kind arrives with bit 1 clear or an I/O kind arrives with bit 0 clear; kinds 4 to 7 are never refused.
- R5: In the same cycle as an outbound request, mst_grant is 0 for kinds 0 to 3 when bit 2 is 0 and 1 otherwise; kinds 4 to 7, including completions, are always granted.
- R6: A rise of intx_line while bit 10 is 0 gives exactly one intx_assert_msg pulse in the next cycle; while bit 10 is 1 no assert pulse is produced.
- R7: A deassert pulse follows one cycle after the line falls or bit 10 becomes 1, but only while an assertion is outstanding; assert and deassert pulses alternate and never coincide.
- R8: Clearing bit 10 while intx_line is still high yields one fresh assert pulse one cycle after the bit has changed.
- R9: One cycle after a fatal (or non-fatal) error detection, the matching message request pulses if bit 8 or the matching device-control report enable is 1, and stays 0 otherwise.
- R10: One cycle after a poisoned inbound request, poison_err_req pulses if bit 6 is 1 or poison_mask is 0; with bit 6 at 0 and poison_mask at 1 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 16 | Write data |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_rd_data | output | 16 | Read data, valid with cfg_rd_valid |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| in_req_valid | input | 1 | Inbound request present |
| in_req_kind | input | 3 | Inbound request kind |
| in_req_poisoned | input | 1 | Inbound request carries poisoned data |
| poison_mask | input | 1 | Poisoned-request error mask |
| in_resp_valid | output | 1 | Inbound decision valid |
| in_resp_ur | output | 1 | Inbound request refused as unsupported |
| poison_err_req | output | 1 | Log and uncorrectable-error message request |
| mst_req_valid | input | 1 | Outbound request from the internal master |
| mst_req_kind | input | 3 | Outbound request kind |
| mst_grant | output | 1 | Outbound request may leave |
| intx_line | input | 1 | Emulated interrupt level |
| intx_assert_msg | output | 1 | Interrupt assert message request pulse |
| intx_deassert_msg | output | 1 | Interrupt deassert message request pulse |
| err_fatal_det | input | 1 | Fatal error detected |
| err_nonfatal_det | input | 1 | Non-fatal error detected |
| dctl_fatal_en | input | 1 | Device control fatal report enable |
| dctl_nonfatal_en | input | 1 | Device control non-fatal report enable |
| err_fatal_msg | output | 1 | Fatal error message request pulse |
| err_nonfatal_msg | output | 1 | Non-fatal error message request pulse |

## Verification
The outbound grant is combinational and is due in the same cycle as the request; read data, inbound decisions, poison, error and interrupt pulses are due one cycle after the inputs that cause them, and a register write changes the decisions that follow it from the next cycle on. Each stimulus cycle, the driver computes every output's expected value from a bench-side register model as it stood before that cycle's write and files it with its due cycle. The monitor samples a quarter period after the falling edge and compares each item whose cycle has come, so pulse outputs are checked at 0 in every quiet cycle as well, which catches double or late messages.

// File: rtl/pcie_cmd_pkg.sv
package pcie_cmd_pkg;

   typedef enum logic [2:0] {
      RK_MEM_RD = 3'd0,
      RK_MEM_WR = 3'd1,
      RK_IO_RD  = 3'd2,
      RK_IO_WR  = 3'd3,
      RK_CFG    = 3'd4,
      RK_MSG    = 3'd5,
      RK_CPL    = 3'd6,
      RK_OTHER  = 3'd7
   } req_kind_e;

   // Bit positions inside the command word
   localparam int BIT_IO_EN     = 0;
   localparam int BIT_MEM_EN    = 1;
   localparam int BIT_BM_EN     = 2;
   localparam int BIT_PERR_RESP = 6;
   localparam int BIT_SERR_EN   = 8;
   localparam int BIT_INT_DIS   = 10;

   // Writable bits: 10, 8, 6, 2, 1, 0
   localparam int CMD_RW_MASK   = 'h0547;
   localparam int CMD_OFFSET    = 'h004;

   function automatic logic kind_is_mem(logic [2:0] k);
      return (k == RK_MEM_RD) || (k == RK_MEM_WR);
   endfunction

   function automatic logic kind_is_io(logic [2:0] k);
      return (k == RK_IO_RD) || (k == RK_IO_WR);
   endfunction

endpackage

// File: rtl/pcie_cmd_regfile.sv
module pcie_cmd_regfile #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 12,
   parameter int OFFSET  = 'h004,
   parameter int RW_MASK = 'h0547
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] cmd_value
);
   localparam int LANES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] OFF_L  = ADDR_W'(OFFSET);
   localparam logic [DATA_W-1:0] MASK_L = DATA_W'(RW_MASK);

   logic hit;
   assign hit = (addr == OFF_L);

   // One storage byte per lane; fixed bits are never stored
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr_en && hit && be[l]) begin
            byte_q <= wdata[8*l +: 8] & MASK_L[8*l +: 8];
         end
      end
      assign cmd_value[8*l +: 8] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= hit ? cmd_value : '0;
         end
      end
   end

   // R3: an upper lane without its enable keeps its value
   a_r3_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[LANES-1]) |=> $stable(cmd_value[DATA_W-1 -: 8]));

   // R3: writes to another offset leave the register alone
   a_r3_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> $stable(cmd_value));

   // R2: fixed and reserved bits read back as zero
   a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((rd_data & ~MASK_L) == '0));

endmodule

// File: rtl/pcie_cmd_access_gate.sv
module pcie_cmd_access_gate
   import pcie_cmd_pkg::*;
#(
   parameter int KIND_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic              io_en,
   input  logic              bm_en,
   input  logic              perr_resp,
   input  logic              poison_mask,
   input  logic              in_valid,
   input  logic [KIND_W-1:0] in_kind,
   input  logic              in_poisoned,
   output logic              in_resp_valid,
   output logic              in_resp_ur,
   output logic              poison_req,
   input  logic              mst_valid,
   input  logic [KIND_W-1:0] mst_kind,
   output logic              mst_grant
);
   logic in_mem, in_io, space_off, poison_hit;
   logic out_gated, grant_d;

   assign in_mem     = kind_is_mem(in_kind);
   assign in_io      = kind_is_io(in_kind);
   assign space_off  = (in_mem && !mem_en) || (in_io && !io_en);
   assign poison_hit = in_valid && in_poisoned && (perr_resp || !poison_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_resp_valid <= 1'b0;
         in_resp_ur    <= 1'b0;
         poison_req    <= 1'b0;
      end else begin
         in_resp_valid <= in_valid;
         in_resp_ur    <= in_valid && space_off;
         poison_req    <= poison_hit;
      end
   end

   // Only memory and I/O requests answer to bus-master enable
   assign out_gated = kind_is_mem(mst_kind) || kind_is_io(mst_kind);
   assign grant_d   = mst_valid && (!out_gated || bm_en);

   if (OUT_REG) begin : g_grant_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mst_grant <= 1'b0;
         else        mst_grant <= grant_d;
      end
   end else begin : g_grant_comb
      assign mst_grant = grant_d;

      // R5: completions always leave
      a_r5_cpl_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (mst_valid && mst_kind == RK_CPL) |-> mst_grant);
      // R5: memory and I/O stay inside while mastering is off
      a_r5_bm_block: assert property (@(posedge clk) disable iff (!rst_n)
         (mst_grant && !bm_en) |-> !(kind_is_mem(mst_kind) || kind_is_io(mst_kind)));
   end

   // R4: disabled memory space refuses memory requests
   a_r4_mem_ur: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && kind_is_mem(in_kind) && !mem_en) |=> in_resp_ur);
   // R4: disabled I/O space refuses I/O requests
   a_r4_io_ur: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && kind_is_io(in_kind) && !io_en) |=> in_resp_ur);
   // R4: other kinds are never refused
   a_r4_other_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !kind_is_mem(in_kind) && !kind_is_io(in_kind)) |=> !in_resp_ur);
   // R10: masked poison with response off stays silent
   a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_poisoned && !perr_resp && poison_mask) |=> !poison_req);

endmodule

// File: rtl/pcie_cmd_intx_msg.sv
module pcie_cmd_intx_msg (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic int_dis,
   output logic assert_msg,
   output logic deassert_msg
);
   logic gated, asserted_q;

   assign gated = line && !int_dis;

   // The outstanding state follows the gated level; each change sends one message
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asserted_q   <= 1'b0;
         assert_msg   <= 1'b0;
         deassert_msg <= 1'b0;
      end else begin
         assert_msg   <= gated && !asserted_q;
         deassert_msg <= !gated && asserted_q;
         asserted_q   <= gated;
      end
   end

   // R6: no assert message while disable was set
   a_r6_dis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(int_dis) |-> !assert_msg);
   // R7: two asserts never follow each other
   a_r7_no_double_assert: assert property (@(posedge clk) disable iff (!rst_n)
      assert_msg |=> !assert_msg);
   // R7: two deasserts never follow each other
   a_r7_no_double_deassert: assert property (@(posedge clk) disable iff (!rst_n)
      deassert_msg |=> !deassert_msg);
   // R7: the two messages never coincide
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(assert_msg && deassert_msg));

endmodule

// File: rtl/pcie_cmd_err_route.sv
module pcie_cmd_err_route #(
   parameter int N_SEV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             serr_en,
   input  logic [N_SEV-1:0] det,
   input  logic [N_SEV-1:0] rep_en,
   output logic [N_SEV-1:0] msg
);
   for (genvar s = 0; s < N_SEV; s++) begin : g_sev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) msg[s] <= 1'b0;
         else        msg[s] <= det[s] && (serr_en || rep_en[s]);
      end

      // R9: without either enable nothing is reported
      a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (det[s] && !serr_en && !rep_en[s]) |=> !msg[s]);
   end

endmodule

// File: rtl/pcie_cmd_gate.sv
module pcie_cmd_gate
   import pcie_cmd_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 12,
   parameter int KIND_W  = 3,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_rd_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [DATA_W/8-1:0] cfg_be,
   output logic [DATA_W-1:0] cfg_rd_data,
   output logic              cfg_rd_valid,
   input  logic              in_req_valid,
   input  logic [KIND_W-1:0] in_req_kind,
   input  logic              in_req_poisoned,
   input  logic              poison_mask,
   output logic              in_resp_valid,
   output logic              in_resp_ur,
   output logic              poison_err_req,
   input  logic              mst_req_valid,
   input  logic [KIND_W-1:0] mst_req_kind,
   output logic              mst_grant,
   input  logic              intx_line,
   output logic              intx_assert_msg,
   output logic              intx_deassert_msg,
   input  logic              err_fatal_det,
   input  logic              err_nonfatal_det,
   input  logic              dctl_fatal_en,
   input  logic              dctl_nonfatal_en,
   output logic              err_fatal_msg,
   output logic              err_nonfatal_msg
);
   localparam int N_SEV = 2;

   initial begin
      assert (DATA_W % 8 == 0 && DATA_W >= 16)
         else $error("DATA_W must be a byte multiple of at least 16");
      assert (KIND_W == 3) else $error("KIND_W must be 3");
      assert (ADDR_W >= 3 && CMD_OFFSET < (1 << ADDR_W))
         else $error("ADDR_W too narrow for the register offset");
   end

   logic [DATA_W-1:0] cmd_value;
   logic [N_SEV-1:0]  err_msg;
   logic              unused_cmd_bits;

   pcie_cmd_regfile #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .OFFSET (CMD_OFFSET),
      .RW_MASK(CMD_RW_MASK)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .rd_en    (cfg_rd_en),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .be       (cfg_be),
      .rd_data  (cfg_rd_data),
      .rd_valid (cfg_rd_valid),
      .cmd_value(cmd_value)
   );

   pcie_cmd_access_gate #(
      .KIND_W (KIND_W),
      .OUT_REG(OUT_REG)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .mem_en       (cmd_value[BIT_MEM_EN]),
      .io_en        (cmd_value[BIT_IO_EN]),
      .bm_en        (cmd_value[BIT_BM_EN]),
      .perr_resp    (cmd_value[BIT_PERR_RESP]),
      .poison_mask  (poison_mask),
      .in_valid     (in_req_valid),
      .in_kind      (in_req_kind),
      .in_poisoned  (in_req_poisoned),
      .in_resp_valid(in_resp_valid),
      .in_resp_ur   (in_resp_ur),
      .poison_req   (poison_err_req),
      .mst_valid    (mst_req_valid),
      .mst_kind     (mst_req_kind),
      .mst_grant    (mst_grant)
   );

   pcie_cmd_intx_msg u_intx (
      .clk         (clk),
      .rst_n       (rst_n),
      .line        (intx_line),
      .int_dis     (cmd_value[BIT_INT_DIS]),
      .assert_msg  (intx_assert_msg),
      .deassert_msg(intx_deassert_msg)
   );

   // Severity index 1 is fatal, 0 is non-fatal
   pcie_cmd_err_route #(
      .N_SEV(N_SEV)
   ) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .serr_en(cmd_value[BIT_SERR_EN]),
      .det    ({err_fatal_det, err_nonfatal_det}),
      .rep_en ({dctl_fatal_en, dctl_nonfatal_en}),
      .msg    (err_msg)
   );

   assign err_fatal_msg    = err_msg[1];
   assign err_nonfatal_msg = err_msg[0];
   assign unused_cmd_bits  = ^cmd_value;

   // R8: with disable cleared and the line held high, an outstanding
   // assertion exists or an assert message is on its way
   a_r8_reassert: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_value[BIT_INT_DIS]) && !cmd_value[BIT_INT_DIS] && intx_line)
      |=> intx_assert_msg);

endmodule

// File: tb/pcie_cmd_gate_tb.sv
module pcie_cmd_gate_tb;

   localparam int RWM = 'h0547;
   localparam int S_RDATA = 0, S_RDV = 1, S_RESPV = 2, S_UR = 3, S_POIS = 4,
                  S_GRANT = 5, S_AS = 6, S_DE = 7, S_EF = 8, S_ENF = 9;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        cfg_wr_en, cfg_rd_en;
   logic [11:0] cfg_addr;
   logic [15:0] cfg_wdata;
   logic [1:0]  cfg_be;
   logic [15:0] cfg_rd_data;
   logic        cfg_rd_valid;
   logic        in_req_valid, in_req_poisoned, poison_mask;
   logic [2:0]  in_req_kind;
   logic        in_resp_valid, in_resp_ur, poison_err_req;
   logic        mst_req_valid;
   logic [2:0]  mst_req_kind;
   logic        mst_grant;
   logic        intx_line, intx_assert_msg, intx_deassert_msg;
   logic        err_fatal_det, err_nonfatal_det, dctl_fatal_en, dctl_nonfatal_en;
   logic        err_fatal_msg, err_nonfatal_msg;

   pcie_cmd_gate u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
      .cfg_rd_data(cfg_rd_data), .cfg_rd_valid(cfg_rd_valid),
      .in_req_valid(in_req_valid), .in_req_kind(in_req_kind),
      .in_req_poisoned(in_req_poisoned), .poison_mask(poison_mask),
      .in_resp_valid(in_resp_valid), .in_resp_ur(in_resp_ur),
      .poison_err_req(poison_err_req),
      .mst_req_valid(mst_req_valid), .mst_req_kind(mst_req_kind), .mst_grant(mst_grant),
      .intx_line(intx_line), .intx_assert_msg(intx_assert_msg),
      .intx_deassert_msg(intx_deassert_msg),
      .err_fatal_det(err_fatal_det), .err_nonfatal_det(err_nonfatal_det),
      .dctl_fatal_en(dctl_fatal_en), .dctl_nonfatal_en(dctl_nonfatal_en),
      .err_fatal_msg(err_fatal_msg), .err_nonfatal_msg(err_nonfatal_msg)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    due;
      int    sig;
      int    exp;
      string req;
   } item_t;
   item_t sb[$];

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   logic [15:0] mcmd = '0;
   logic  m_asserted = 1'b0;
   string rd_tag = "R2";
   string as_tag = "R6";
   string de_tag = "R7";

   function automatic int sample(int s);
      case (s)
         S_RDATA: return int'(cfg_rd_data);
         S_RDV:   return int'(cfg_rd_valid);
         S_RESPV: return int'(in_resp_valid);
         S_UR:    return int'(in_resp_ur);
         S_POIS:  return int'(poison_err_req);
         S_GRANT: return int'(mst_grant);
         S_AS:    return int'(intx_assert_msg);
         S_DE:    return int'(intx_deassert_msg);
         S_EF:    return int'(err_fatal_msg);
         default: return int'(err_nonfatal_msg);
      endcase
   endfunction

   task automatic push(int due, int sig, int exp, string req);
      sb.push_back('{due, sig, exp, req});
   endtask

   // Monitor: a quarter period after the falling edge
   always begin
      @(negedge clk);
      #5;
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due <= cyc) begin
            n_chk++;
            if (sb[i].due < cyc || sample(sb[i].sig) != sb[i].exp) begin
               n_fail++;
               $display("FAIL %s output %0d cycle %0d: actual %0h expected %0h",
                        sb[i].req, sb[i].sig, cyc, sample(sb[i].sig), sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   task automatic clear_strobes();
      cfg_wr_en = 0; cfg_rd_en = 0; in_req_valid = 0; in_req_poisoned = 0;
      mst_req_valid = 0; err_fatal_det = 0; err_nonfatal_det = 0;
   endtask

   // Driver: file expectations for the drives of this cycle, then advance
   task automatic step_cycle();
      logic ur, gl;
      ur = in_req_valid &&
           ((in_req_kind <= 3'd1 && !mcmd[1]) ||
            ((in_req_kind == 3'd2 || in_req_kind == 3'd3) && !mcmd[0]));
      push(cyc + 1, S_RDV, int'(cfg_rd_en), "R2");
      if (cfg_rd_en) push(cyc + 1, S_RDATA, (cfg_addr == 12'h004) ? int'(mcmd) : 0, rd_tag);
      push(cyc + 1, S_RESPV, int'(in_req_valid), "R4");
      push(cyc + 1, S_UR, int'(ur), "R4");
      push(cyc + 1, S_POIS,
           int'(in_req_valid && in_req_poisoned && (mcmd[6] || !poison_mask)), "R10");
      push(cyc, S_GRANT, int'(mst_req_valid && (mst_req_kind > 3'd3 || mcmd[2])), "R5");
      gl = intx_line && !mcmd[10];
      push(cyc + 1, S_AS, int'(gl && !m_asserted), as_tag);
      push(cyc + 1, S_DE, int'(!gl && m_asserted), de_tag);
      m_asserted = gl;
      push(cyc + 1, S_EF, int'(err_fatal_det && (mcmd[8] || dctl_fatal_en)), "R9");
      push(cyc + 1, S_ENF, int'(err_nonfatal_det && (mcmd[8] || dctl_nonfatal_en)), "R9");
      if (cfg_wr_en && cfg_addr == 12'h004) begin
         if (cfg_be[0]) mcmd[7:0]  = cfg_wdata[7:0]  & RWM[7:0];
         if (cfg_be[1]) mcmd[15:8] = cfg_wdata[15:8] & RWM[15:8];
      end
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic cfg_write(logic [11:0] a, logic [15:0] d, logic [1:0] b);
      cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
      step_cycle();
   endtask

   task automatic cfg_read(logic [11:0] a, string tag);
      rd_tag = tag;
      cfg_rd_en = 1; cfg_addr = a;
      step_cycle();
      rd_tag = "R2";
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step_cycle();
   endtask

   initial begin
      rst_n = 0; clear_strobes();
      cfg_addr = '0; cfg_wdata = '0; cfg_be = '0; in_req_kind = '0; mst_req_kind = '0;
      poison_mask = 0; intx_line = 0; dctl_fatal_en = 0; dctl_nonfatal_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset value and quiet outputs
      cfg_read(12'h004, "R1");
      idle(2);

      // R2: only the writable mask survives, other offsets read zero
      cfg_write(12'h004, 16'hFFFF, 2'b11);
      cfg_read(12'h004, "R2");
      cfg_read(12'h008, "R2");

      // R3: byte enables and offset decoding
      cfg_write(12'h004, 16'h0000, 2'b01);
      cfg_read(12'h004, "R3");
      cfg_write(12'h004, 16'hFFFF, 2'b00);
      cfg_read(12'h004, "R3");
      cfg_write(12'h008, 16'h0000, 2'b11);
      cfg_read(12'h004, "R3");
      cfg_write(12'h004, 16'h0000, 2'b10);
      cfg_read(12'h004, "R3");

      // R4: inbound decisions for each space setting
      for (int m = 0; m < 4; m++) begin
         cfg_write(12'h004, 16'(m), 2'b01);
         for (int k = 0; k < 8; k++) begin
            in_req_valid = 1; in_req_kind = 3'(k);
            step_cycle();
         end
      end

      // R5: outbound gating with mastering off then on
      for (int b = 0; b < 2; b++) begin
         cfg_write(12'h004, b ? 16'h0004 : 16'h0000, 2'b01);
         for (int k = 0; k < 8; k++) begin
            mst_req_valid = 1; mst_req_kind = 3'(k);
            step_cycle();
         end
      end

      // R10: poison response against the mask
      for (int p = 0; p < 2; p++) begin
         cfg_write(12'h004, p ? 16'h0040 : 16'h0000, 2'b01);
         for (int mk = 0; mk < 2; mk++) begin
            poison_mask = mk[0];
            in_req_valid = 1; in_req_poisoned = 1; in_req_kind = 3'd1;
            step_cycle();
         end
      end
      poison_mask = 0;

      // R9: error routing against both enables
      for (int s = 0; s < 2; s++) begin
         cfg_write(12'h004, s ? 16'h0100 : 16'h0000, 2'b10);
         for (int e = 0; e < 4; e++) begin
            dctl_fatal_en = e[0]; dctl_nonfatal_en = e[1];
            err_fatal_det = 1; err_nonfatal_det = 1;
            step_cycle();
         end
      end
      dctl_fatal_en = 0; dctl_nonfatal_en = 0;
      cfg_write(12'h004, 16'h0000, 2'b11);

      // R6: assert on the rising line; R7: deassert on the fall
      intx_line = 1; idle(3);
      intx_line = 0; idle(3);
      // R7: setting disable withdraws the outstanding assertion
      intx_line = 1; idle(2);
      cfg_write(12'h004, 16'h0400, 2'b10);
      idle(3);
      // R7: a fall while disabled sends nothing; R6: a rise while disabled neither
      intx_line = 0; idle(2);
      intx_line = 1; idle(2);
      // R8: clearing disable with the line high sends a fresh assert
      as_tag = "R8";
      cfg_write(12'h004, 16'h0000, 2'b10);
      idle(3);
      as_tag = "R6";
      intx_line = 0; idle(3);

      idle(3);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule